// File: doc/BRIEF.md
# Inverter Gate Shutdown Output Stage

This block sits between a three-phase PWM generator and the gate-driver pins. It takes six raw gate commands (a high-side and a low-side switch for each of three phases) and one brake-chopper command, and registers them onto the output pins through a polarity stage that can be set for each output. The six phase gates reset to active-high. The brake output resets to active-low.

Two independent shutdown paths act on the outputs. In the first path, an active-low fault input and an active-low over-current trip input each pass through a synchroniser and a digital run-length filter with its own programmable length. Either one, once qualified, sets a sticky flag that holds all six phase gates at their inactive level. Software clears the flag with a clear pulse, and the clear is honoured only while both synchronised inputs are idle. In the second path, an active-low brake shutdown input forces only the brake output inactive for as long as it stays low. It does not touch the phase gates.

Top module: `gate_kill_stage`

## Requirements
- R1: While reset is low and on the first cycle after it: all six phase gates read 0, `brake_out` reads 1 and `fault_flag` reads 0. The polarity register resets to 7'b1000000.
- R2: With no shutdown active, each `gate_out[i]` equals `pwm_raw[i] ^ pol[i]` one clock after the raw value is sampled, and `brake_out` equals `brake_raw ^ pol[6]`.
  - Bit i of the polarity register is 1 for an active-low output.
  - Gate order is U-high, U-low, V-high, V-low, W-high, W-low for bits 0 to 5.
- R3: Holding `fault_n` low for at least L clocks (L = `fault_len`, value 0 treated as 1) sets `fault_flag` and drives all six gates to their inactive level (equal to their polarity bit).
  - The clock edge on which this happens is the (L+2)-th edge that samples the low level.
- R4: A fault or trip pulse shorter than its filter length leaves the flag and the gates unaffected.
- R5: `trip_n` has the same kill and sticky behaviour as `fault_n`, qualified by its own length `trip_len`.
- R6: A low on `brake_kill_n` forces `brake_out` to its inactive level (pol[6]) from the third sampling edge, and only while it stays low. The phase gates are unaffected by it, and the fault and trip paths never change `brake_out`.
- R7: Once set, `fault_flag` and the gate kill persist after the inputs return high. They end on the edge that samples `flag_clr` high while both synchronised fault and trip inputs are high.
- R8: A `flag_clr` pulse given while the synchronised fault or trip input is still low has no effect.
- R9: Filter length 0 qualifies on a single low clock. Length 255 rejects a 254-clock pulse and accepts a 255-clock pulse.
- R10: A `pol_we` pulse loads `pol_din` into the polarity register, and the outputs use the new polarity from the following edge. This includes the inactive level of killed outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_raw | input | 6 | Raw phase gate commands, bit 0 U-high to bit 5 W-low |
| brake_raw | input | 1 | Raw brake chopper command |
| fault_n | input | 1 | Asynchronous active-low fault request |
| trip_n | input | 1 | Asynchronous active-low over-current trip |
| brake_kill_n | input | 1 | Asynchronous active-low brake shutdown |
| fault_len | input | 8 | Fault filter length in clocks (0 acts as 1) |
| trip_len | input | 8 | Trip filter length in clocks (0 acts as 1) |
| pol_we | input | 1 | Polarity register write strobe |
| pol_din | input | 7 | New polarity, bit 6 brake, 1 = active-low |
| flag_clr | input | 1 | Software clear of the sticky shutdown flag |
| gate_out | output | 6 | Phase gate outputs to the drivers |
| brake_out | output | 1 | Brake chopper output |
| fault_flag | output | 1 | Sticky phase shutdown flag |

## Verification
Two coincidences matter most. The first is a software clear arriving in the same cycle as a fault or trip input that is still low. The bench holds `fault_n` low across a `flag_clr` pulse, and separately pulses `flag_clr` while a new trip is qualifying. The flag must stay set in both cases. The second is a brake shutdown overlapping a latched phase kill. Both are applied together and released at different times, and the reference model, compared on every clock, must see the brake and the phase gates follow their own paths independently.

// File: rtl/gks_pkg.sv
// Package: shared constants and types for the gate shutdown stage.
// Assumes the phase gate order U-high, U-low, V-high, V-low, W-high, W-low.
package gks_pkg;
    localparam int NUM_PHASE_GATES = 6;
    localparam int NUM_TRIP_SRC    = 2;   // fault and over-current trip
    localparam int NUM_SYNC_SIG    = 3;   // fault, trip, brake shutdown
    localparam int POL_W           = NUM_PHASE_GATES + 1;

    typedef logic [NUM_PHASE_GATES-1:0] gate_vec_t;

    // Indices into the synchronised input vector
    typedef enum int {
        SYN_FAULT = 0,
        SYN_TRIP  = 1,
        SYN_BRAKE = 2
    } sync_idx_e;

    // Reset polarity: phase gates active-high, brake active-low
    localparam logic [POL_W-1:0] POL_RESET = {1'b1, {NUM_PHASE_GATES{1'b0}}};
endpackage

// File: rtl/gks_sync.sv
// Module: multi-stage synchroniser for a vector of asynchronous active-low inputs.
// Assumes the inputs idle high, so every stage resets to all ones.
module gks_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int CHAIN_W = W * STAGES;

    logic [CHAIN_W-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            // Single-stage capture of the asynchronous inputs
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= din;
            end
        end else begin : g_multi
            // Shift the inputs through STAGES flops
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[CHAIN_W-W-1:0], din};
            end
        end
    endgenerate

    assign dout = chain_q[CHAIN_W-1 -: W];
endmodule

// File: rtl/gks_glitch_filter.sv
// Module: run-length filter for one synchronised active-low request.
// It reports a hit in any cycle where the input has been low for at least
// len consecutive samples, this one included. A len of 0 is treated as 1.
// The run counter saturates at its maximum value.
module gks_glitch_filter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_n,
    input  logic [CW-1:0] len,
    output logic          hit
);
    localparam logic [CW-1:0] CNT_MAX = '1;

    logic [CW-1:0] run_q;
    logic [CW:0]   run_next;
    logic [CW:0]   eff_len;

    // Effective length with zero clamped to one
    always_comb begin
        eff_len  = (len == '0) ? {{CW{1'b0}}, 1'b1} : {1'b0, len};
        run_next = {1'b0, run_q} + 1'b1;
        hit      = !req_n && (run_next >= eff_len);
    end

    // Count consecutive low samples, restart on a high sample
    always_ff @(posedge clk) begin
        if (!rst_n)              run_q <= '0;
        else if (req_n)          run_q <= '0;
        else if (run_q != CNT_MAX) run_q <= run_q + 1'b1;
    end
endmodule

// File: rtl/gks_kill_latch.sv
// Module: sticky shutdown flag shared by all qualified phase-kill sources.
// Assumes clr_ok is high only while every source input is idle.
// A new hit always wins over a clear in the same cycle.
module gks_kill_latch #(
    parameter int NSRC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] hits,
    input  logic            clr,
    input  logic            clr_ok,
    output logic            flag,
    output logic            kill
);
    logic any_hit;

    // Merge the sources and form the immediate kill
    always_comb begin
        any_hit = |hits;
        kill    = flag | any_hit;
    end

    // Set on any hit, clear only on a permitted software clear
    always_ff @(posedge clk) begin
        if (!rst_n)             flag <= 1'b0;
        else if (any_hit)       flag <= 1'b1;
        else if (clr && clr_ok) flag <= 1'b0;
    end
endmodule

// File: rtl/gks_out_drive.sv
// Module: registered output drivers with polarity for each bit.
// While kill is high every bit takes its inactive level, which equals its
// polarity bit. Otherwise the raw command is passed through the polarity.
// RST_LVL gives the level that each pin holds during reset.
module gks_out_drive #(
    parameter int           N       = 6,
    parameter logic [N-1:0] RST_LVL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    input  logic [N-1:0] pol,
    input  logic         kill,
    output logic [N-1:0] pin
);
    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_bit
            // Register one output pin at its inactive or commanded level
            always_ff @(posedge clk) begin
                if (!rst_n)    pin[i] <= RST_LVL[i];
                else if (kill) pin[i] <= pol[i];
                else           pin[i] <= raw[i] ^ pol[i];
            end
        end
    endgenerate
endmodule

// File: rtl/gate_kill_stage.sv
// Module: top of the gate shutdown output stage.
// The fault and trip requests are synchronised, filtered and latched into
// one sticky phase-kill flag. The brake shutdown is synchronised and acts
// on the brake output alone, only while it is asserted.
// Assumes the three shutdown inputs are asynchronous and idle high, and
// that the length inputs are static while a request is being qualified.
module gate_kill_stage
    import gks_pkg::*;
#(
    parameter int FILT_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_PHASE_GATES-1:0] pwm_raw,
    input  logic                       brake_raw,
    input  logic                       fault_n,
    input  logic                       trip_n,
    input  logic                       brake_kill_n,
    input  logic [FILT_W-1:0]          fault_len,
    input  logic [FILT_W-1:0]          trip_len,
    input  logic                       pol_we,
    input  logic [POL_W-1:0]           pol_din,
    input  logic                       flag_clr,
    output logic [NUM_PHASE_GATES-1:0] gate_out,
    output logic                       brake_out,
    output logic                       fault_flag
);
    logic [NUM_SYNC_SIG-1:0] async_in;
    logic [NUM_SYNC_SIG-1:0] sync_in;
    logic [NUM_TRIP_SRC-1:0] src_req_n;
    logic [FILT_W-1:0]       src_len [NUM_TRIP_SRC];
    logic [NUM_TRIP_SRC-1:0] src_hit;
    logic [POL_W-1:0]        pol_q;
    logic                    clr_ok;
    logic                    bk_idle;
    logic                    phase_kill;

    // Gather the asynchronous inputs in the package index order
    always_comb begin
        async_in            = '1;
        async_in[SYN_FAULT] = fault_n;
        async_in[SYN_TRIP]  = trip_n;
        async_in[SYN_BRAKE] = brake_kill_n;
        src_req_n[0]        = sync_in[SYN_FAULT];
        src_req_n[1]        = sync_in[SYN_TRIP];
        src_len[0]          = fault_len;
        src_len[1]          = trip_len;
        clr_ok              = sync_in[SYN_FAULT] & sync_in[SYN_TRIP];
        bk_idle             = sync_in[SYN_BRAKE];
    end

    gks_sync #(
        .W      (NUM_SYNC_SIG),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (async_in),
        .dout  (sync_in)
    );

    genvar s;
    generate
        for (s = 0; s < NUM_TRIP_SRC; s++) begin : g_filt
            gks_glitch_filter #(
                .CW (FILT_W)
            ) u_filt (
                .clk   (clk),
                .rst_n (rst_n),
                .req_n (src_req_n[s]),
                .len   (src_len[s]),
                .hit   (src_hit[s])
            );
        end
    endgenerate

    gks_kill_latch #(
        .NSRC (NUM_TRIP_SRC)
    ) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .hits   (src_hit),
        .clr    (flag_clr),
        .clr_ok (clr_ok),
        .flag   (fault_flag),
        .kill   (phase_kill)
    );

    // Polarity register, loaded by a write strobe
    always_ff @(posedge clk) begin
        if (!rst_n)      pol_q <= POL_RESET;
        else if (pol_we) pol_q <= pol_din;
    end

    gks_out_drive #(
        .N       (NUM_PHASE_GATES),
        .RST_LVL (POL_RESET[NUM_PHASE_GATES-1:0])
    ) u_phase_drv (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (pwm_raw),
        .pol   (pol_q[NUM_PHASE_GATES-1:0]),
        .kill  (phase_kill),
        .pin   (gate_out)
    );

    gks_out_drive #(
        .N       (1),
        .RST_LVL (POL_RESET[NUM_PHASE_GATES])
    ) u_brake_drv (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (brake_raw),
        .pol   (pol_q[NUM_PHASE_GATES]),
        .kill  (!bk_idle),
        .pin   (brake_out)
    );
endmodule

// Checker: temporal properties of the shutdown stage, bound to the top.
module gks_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [5:0] gate_out,
    input logic       brake_out,
    input logic       fault_flag,
    input logic       flag_clr,
    input logic [6:0] pol_q,
    input logic       clr_ok,
    input logic       bk_idle
);
    // R3
    killed_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_flag |-> (gate_out == $past(pol_q[5:0])));

    // R7
    sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_flag && !flag_clr) |=> fault_flag);

    // R7
    clear_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_flag && flag_clr && clr_ok) |=> !fault_flag);

    // R8
    clear_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_flag && !clr_ok) |=> fault_flag);

    // R6
    brake_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bk_idle |=> (brake_out == $past(pol_q[6])));
endmodule

bind gate_kill_stage gks_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .gate_out   (gate_out),
    .brake_out  (brake_out),
    .fault_flag (fault_flag),
    .flag_clr   (flag_clr),
    .pol_q      (pol_q),
    .clr_ok     (clr_ok),
    .bk_idle    (bk_idle)
);

// File: tb/gate_kill_stage_bench.sv
// Bench: behavioural reference model compared with the outputs on every clock.
module gate_kill_stage_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [5:0] pwm_raw;
    logic       brake_raw, fault_n, trip_n, brake_kill_n;
    logic [7:0] fault_len, trip_len;
    logic       pol_we, flag_clr;
    logic [6:0] pol_din;
    logic [5:0] gate_out;
    logic       brake_out, fault_flag;

    int    total = 0;
    int    bad   = 0;
    string cur_req = "R1";

    // Reference model state
    bit   f_q[$], t_q[$], b_q[$];   // synchroniser delay lines
    int   f_run, t_run;
    bit   m_flag, m_brake;
    bit [5:0] m_gate;
    bit [6:0] m_pol;

    always #10 clk = ~clk;

    gate_kill_stage u_gate_kill_stage (
        .clk(clk), .rst_n(rst_n), .pwm_raw(pwm_raw), .brake_raw(brake_raw),
        .fault_n(fault_n), .trip_n(trip_n), .brake_kill_n(brake_kill_n),
        .fault_len(fault_len), .trip_len(trip_len), .pol_we(pol_we),
        .pol_din(pol_din), .flag_clr(flag_clr), .gate_out(gate_out),
        .brake_out(brake_out), .fault_flag(fault_flag));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        f_q = '{1, 1}; t_q = '{1, 1}; b_q = '{1, 1};
        f_run = 0; t_run = 0;
        m_flag = 0; m_gate = 6'b0; m_brake = 1; m_pol = 7'b1000000;
    endtask

    // One rising edge of the reference, using the inputs now applied
    task automatic model_step();
        bit fs, ts, bs, hf, ht, kill;
        int ef, et;
        fs = f_q[0]; ts = t_q[0]; bs = b_q[0];
        ef = (fault_len == 0) ? 1 : fault_len;
        et = (trip_len == 0) ? 1 : trip_len;
        hf = !fs && (f_run + 1 >= ef);
        ht = !ts && (t_run + 1 >= et);
        kill = m_flag || hf || ht;
        m_gate  = kill ? m_pol[5:0] : (pwm_raw ^ m_pol[5:0]);
        m_brake = !bs ? m_pol[6] : (brake_raw ^ m_pol[6]);
        if (hf || ht) m_flag = 1;
        else if (flag_clr && fs && ts) m_flag = 0;
        f_run = fs ? 0 : ((f_run < 255) ? f_run + 1 : 255);
        t_run = ts ? 0 : ((t_run < 255) ? t_run + 1 : 255);
        void'(f_q.pop_front()); f_q.push_back(fault_n);
        void'(t_q.pop_front()); t_q.push_back(trip_n);
        void'(b_q.pop_front()); b_q.push_back(brake_kill_n);
        if (pol_we) m_pol = pol_din;
    endtask

    // Advance one clock and compare all outputs at the falling edge
    task automatic cycle();
        if (!rst_n) model_reset(); else model_step();
        @(negedge clk);
        check({gate_out, brake_out, fault_flag} == {m_gate, m_brake, m_flag},
              cur_req, {gate_out, brake_out, fault_flag}, {m_gate, m_brake, m_flag});
    endtask

    task automatic run(input int n);
        for (int k = 0; k < n; k++) begin
            pwm_raw   = 6'(k * 13 + 5);
            brake_raw = k[1];
            cycle();
        end
    endtask

    task automatic do_clear();
        flag_clr = 1; cycle(); flag_clr = 0; cycle();
    endtask

    initial begin
        #(20 * 150000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 0; pwm_raw = 6'h2A; brake_raw = 1; fault_n = 1; trip_n = 1;
        brake_kill_n = 1; fault_len = 8; trip_len = 4; pol_we = 0;
        pol_din = 0; flag_clr = 0;
        model_reset();
        @(negedge clk);
        for (int k = 0; k < 3; k++) cycle();
        // R1 reset state
        check(gate_out == 6'b0 && brake_out && !fault_flag, "R1",
              {gate_out, brake_out, fault_flag}, 8'b0000_0010);
        rst_n = 1;
        cur_req = "R2"; run(20);
        pwm_raw = 6'b110100; brake_raw = 0; cycle(); cycle();
        check(gate_out == 6'b110100 && brake_out == 1, "R2", {gate_out, brake_out}, 7'b1101001);
        // R10 polarity change
        cur_req = "R10"; pol_din = 7'b0101101; pol_we = 1; cycle(); pol_we = 0;
        pwm_raw = 6'b000000; brake_raw = 0; cycle(); cycle();
        check(gate_out == 6'b101101 && !brake_out, "R10", {gate_out, brake_out}, 7'b1011010);
        run(10);
        pol_din = 7'b1000000; pol_we = 1; cycle(); pol_we = 0;
        // R4 short fault pulse
        cur_req = "R4"; fault_n = 0; run(7); fault_n = 1; run(6);
        check(!fault_flag, "R4", fault_flag, 0);
        // R3 qualified fault, latency L+2
        cur_req = "R3"; pwm_raw = 6'b111111; fault_n = 0;
        for (int k = 1; k <= 9; k++) cycle();
        check(gate_out == 6'b111111, "R3", gate_out, 6'h3F);
        cycle();
        check(gate_out == 6'b000000 && fault_flag, "R3", {gate_out, fault_flag}, 7'b0000001);
        // R8 clear while still low
        cur_req = "R8"; do_clear();
        check(fault_flag, "R8", fault_flag, 1);
        // R7 sticky after release
        cur_req = "R7"; fault_n = 1; run(8);
        check(fault_flag && gate_out == 6'b0, "R7", {gate_out, fault_flag}, 7'b0000001);
        // R10 killed outputs follow new inactive level
        cur_req = "R10"; pol_din = 7'b1010101; pol_we = 1; cycle(); pol_we = 0; cycle();
        check(gate_out == 6'b010101, "R10", gate_out, 6'h15);
        pol_din = 7'b1000000; pol_we = 1; cycle(); pol_we = 0;
        cur_req = "R7"; do_clear();
        check(!fault_flag, "R7", fault_flag, 0);
        run(5);
        // R5 trip path, with a clear during qualification (R8)
        cur_req = "R5"; trip_n = 0; run(2); flag_clr = 1; run(3); flag_clr = 0; run(2);
        check(fault_flag, "R5", fault_flag, 1);
        trip_n = 1; run(4); do_clear();
        check(!fault_flag, "R5", fault_flag, 0);
        // R6 brake kill, overlapping with a latched phase kill
        cur_req = "R6"; brake_kill_n = 0; brake_raw = 1; pwm_raw = 6'b100001; cycle(); cycle(); cycle();
        check(brake_out == 1 && gate_out == 6'b100001, "R6", {gate_out, brake_out}, 7'b1000011);
        fault_n = 0; run(12); fault_n = 1; run(3);
        brake_kill_n = 1; brake_raw = 1; cycle(); cycle(); cycle();
        check(brake_out == 0 && fault_flag, "R6", {brake_out, fault_flag}, 1);
        run(4); do_clear(); run(3);
        // R9 length limits
        cur_req = "R9"; fault_len = 0; fault_n = 0; cycle(); fault_n = 1; run(4);
        check(fault_flag, "R9", fault_flag, 1);
        run(2); do_clear();
        fault_len = 255; fault_n = 0; run(254); fault_n = 1; run(5);
        check(!fault_flag, "R9", fault_flag, 0);
        fault_n = 0; run(255); fault_n = 1; run(4);
        check(fault_flag, "R9", fault_flag, 1);
        run(2); do_clear(); run(5);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule